// File: doc/BRIEF.md
# Linear-Count Video Timing Generator

This block produces the sync, display-enable and pixel stream for an external TV-style pixel path. Horizontal timing comes from a line counter that wraps every line period. Vertical timing does not use a line counter. One counter runs over the whole frame in pixel clocks. Vertical sync, the vertical display window and the frame boundary are all positions on that counter. Software therefore programs frame period, sync length and window limits as pixel counts, normally lines multiplied by the line period.

All configuration pins are copied into an active register set. While the generator is stopped, the copy happens on every cycle. While it is running, the copy happens only on the last pixel of a frame. Changing a setting in mid-frame, or dropping enable, never leaves a frame with mixed settings. The pixel input is a valid/ready stream. The block asserts `pix_ready` exactly in display-window cycles and never waits for the source. A window cycle without `pix_valid` is an underflow, and the underflow colour is driven in place of pixel data. The output side is raw video timing and has no back-pressure.

Top module: `frame_linear_vtg`

## Requirements
- R1: Horizontal sync is active for line-counter positions 0 to `cfg_hpulse`-1. The line counter runs from 0 to `cfg_hperiod`-1 and restarts at 0 at every frame start.
- R2: Vertical sync is active for frame-counter positions `cfg_skew` to `cfg_skew`+`cfg_vlen`-1. The frame counter runs from 0 to `cfg_fperiod`-1.
- R3: `vid_de` is high only while the generator runs, the line position is within [`cfg_hstart`, `cfg_hend`] and the frame position is within [`cfg_vstart`, `cfg_vend`]. Both ranges include their end values.
- R4: While running, `vid_pixel` carries `pix_data` in window cycles and `cfg_border` outside the window. While stopped, it is zero.
- R5: `frame_start` is high for exactly one cycle, when the frame position is 0. It recurs every `cfg_fperiod` cycles.
- R6: While running, configuration changes take effect only from the first cycle of the next frame. While stopped, they take effect on the next cycle.
- R7: A polarity bit set to 1 makes its sync active low (`cfg_hsync_low`, `cfg_vsync_low`). While stopped, each sync sits at its inactive level.
- R8: A window cycle with `pix_valid` low drives `cfg_uf_color` on `vid_pixel`. Every later window cycle also shows that colour until the underflow is cleared.
- R9: With `cfg_uf_recover` set, a pending underflow clears at the frame boundary, and pixel data resumes in the next frame. With it clear, the underflow persists until the generator stops.
- R10: Clearing `cfg_enable` finishes the current frame. From the cycle after its last pixel, `vid_de` is low, the syncs are inactive and `frame_start` stays low.
- R11: `pix_ready` equals `vid_de`. A pixel is consumed only in display-window cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Run request |
| cfg_hperiod | input | HW | Pixels per line |
| cfg_hpulse | input | HW | Horizontal sync width in pixels |
| cfg_hstart | input | HW | First display pixel in a line |
| cfg_hend | input | HW | Last display pixel in a line (inclusive) |
| cfg_fperiod | input | FW | Pixels per frame |
| cfg_vlen | input | FW | Vertical sync length in pixels |
| cfg_vstart | input | FW | First display position in the frame |
| cfg_vend | input | FW | Last display position in the frame (inclusive) |
| cfg_skew | input | HW | Vertical sync offset in pixels |
| cfg_hsync_low | input | 1 | 1: horizontal sync active low |
| cfg_vsync_low | input | 1 | 1: vertical sync active low |
| cfg_border | input | PW | Colour outside the display window |
| cfg_uf_color | input | PW | Colour shown during underflow |
| cfg_uf_recover | input | 1 | 1: clear underflow at frame boundary |
| pix_valid | input | 1 | Upstream pixel available |
| pix_ready | output | 1 | Pixel consumed this cycle |
| pix_data | input | PW | Upstream pixel value |
| vid_hsync | output | 1 | Horizontal sync |
| vid_vsync | output | 1 | Vertical sync |
| vid_de | output | 1 | Display enable |
| vid_pixel | output | PW | Selected pixel value |
| frame_start | output | 1 | First cycle of each frame |

## Verification
A frame counter that is off by one moves `frame_start` away from its expected period. The same fault shifts vertical sync and the display window by a whole line or a single pixel, and all of this shows within the first frame. A shadow copy taken at the wrong moment shows up as a sync width or polarity change that starts mid-frame instead of at `frame_start`. A stuck or early-cleared underflow flag shows as underflow colour where pixel data is expected, or the reverse, on the next window cycle. Every cycle of every scanned frame is compared against an expected model computed from the frame position.

// File: rtl/flvtg_pkg.sv
package flvtg_pkg;
  typedef enum logic [1:0] {
    SEL_BLANK  = 2'd0,
    SEL_BORDER = 2'd1,
    SEL_PIXEL  = 2'd2,
    SEL_UFILL  = 2'd3
  } pix_sel_e;
endpackage

// File: rtl/flvtg_shadow.sv
module flvtg_shadow #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          in_en,
  input  logic [HW-1:0] in_hperiod,
  input  logic [HW-1:0] in_hpulse,
  input  logic [HW-1:0] in_hstart,
  input  logic [HW-1:0] in_hend,
  input  logic [FW-1:0] in_fperiod,
  input  logic [FW-1:0] in_vlen,
  input  logic [FW-1:0] in_vstart,
  input  logic [FW-1:0] in_vend,
  input  logic [HW-1:0] in_skew,
  input  logic          in_hpol,
  input  logic          in_vpol,
  input  logic [PW-1:0] in_border,
  input  logic [PW-1:0] in_ufcol,
  input  logic          in_recover,
  output logic          q_en,
  output logic [HW-1:0] q_hperiod,
  output logic [HW-1:0] q_hpulse,
  output logic [HW-1:0] q_hstart,
  output logic [HW-1:0] q_hend,
  output logic [FW-1:0] q_fperiod,
  output logic [FW-1:0] q_vlen,
  output logic [FW-1:0] q_vstart,
  output logic [FW-1:0] q_vend,
  output logic [HW-1:0] q_skew,
  output logic          q_hpol,
  output logic          q_vpol,
  output logic [PW-1:0] q_border,
  output logic [PW-1:0] q_ufcol,
  output logic          q_recover
);
  // Active set: reloaded continuously when stopped, at frame end when running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_en      <= 1'b0;
      q_hperiod <= '0;
      q_hpulse  <= '0;
      q_hstart  <= '0;
      q_hend    <= '0;
      q_fperiod <= '0;
      q_vlen    <= '0;
      q_vstart  <= '0;
      q_vend    <= '0;
      q_skew    <= '0;
      q_hpol    <= 1'b0;
      q_vpol    <= 1'b0;
      q_border  <= '0;
      q_ufcol   <= '0;
      q_recover <= 1'b0;
    end else if (load) begin
      q_en      <= in_en;
      q_hperiod <= in_hperiod;
      q_hpulse  <= in_hpulse;
      q_hstart  <= in_hstart;
      q_hend    <= in_hend;
      q_fperiod <= in_fperiod;
      q_vlen    <= in_vlen;
      q_vstart  <= in_vstart;
      q_vend    <= in_vend;
      q_skew    <= in_skew;
      q_hpol    <= in_hpol;
      q_vpol    <= in_vpol;
      q_border  <= in_border;
      q_ufcol   <= in_ufcol;
      q_recover <= in_recover;
    end
  end
endmodule

// File: rtl/flvtg_counters.sv
module flvtg_counters #(
  parameter int HW = 12,
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] hperiod,
  input  logic [FW-1:0] fperiod,
  output logic [HW-1:0] hcnt,
  output logic [FW-1:0] fcnt,
  output logic          wrap
);
  logic [FW:0] f_next;
  logic [HW:0] h_next;
  logic        line_end;

  assign f_next   = {1'b0, fcnt} + 1'b1;
  assign h_next   = {1'b0, hcnt} + 1'b1;
  assign wrap     = run && (f_next >= {1'b0, fperiod});
  assign line_end = h_next >= {1'b0, hperiod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      fcnt <= '0;
    end else if (!run || wrap) begin
      hcnt <= '0;
      fcnt <= '0;
    end else begin
      fcnt <= f_next[FW-1:0];
      hcnt <= line_end ? '0 : h_next[HW-1:0];
    end
  end
endmodule

// File: rtl/flvtg_pixsel.sv
module flvtg_pixsel
  import flvtg_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          de,
  input  logic          wrap,
  input  logic          recover,
  input  logic          pix_valid,
  input  logic [PW-1:0] pix_data,
  input  logic [PW-1:0] border,
  input  logic [PW-1:0] ufcol,
  output logic [PW-1:0] pixel
);
  logic     uf_hold;
  pix_sel_e sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 uf_hold <= 1'b0;
    else if (!run)              uf_hold <= 1'b0;
    else if (wrap && recover)   uf_hold <= 1'b0;
    else if (de && !pix_valid)  uf_hold <= 1'b1;
  end

  always_comb begin
    if (!run)                         sel = SEL_BLANK;
    else if (!de)                     sel = SEL_BORDER;
    else if (uf_hold || !pix_valid)   sel = SEL_UFILL;
    else                              sel = SEL_PIXEL;
  end

  always_comb begin
    unique case (sel)
      SEL_BORDER: pixel = border;
      SEL_PIXEL:  pixel = pix_data;
      SEL_UFILL:  pixel = ufcol;
      default:    pixel = '0;
    endcase
  end
endmodule

// File: rtl/frame_linear_vtg.sv
module frame_linear_vtg #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [HW-1:0] cfg_hperiod,
  input  logic [HW-1:0] cfg_hpulse,
  input  logic [HW-1:0] cfg_hstart,
  input  logic [HW-1:0] cfg_hend,
  input  logic [FW-1:0] cfg_fperiod,
  input  logic [FW-1:0] cfg_vlen,
  input  logic [FW-1:0] cfg_vstart,
  input  logic [FW-1:0] cfg_vend,
  input  logic [HW-1:0] cfg_skew,
  input  logic          cfg_hsync_low,
  input  logic          cfg_vsync_low,
  input  logic [PW-1:0] cfg_border,
  input  logic [PW-1:0] cfg_uf_color,
  input  logic          cfg_uf_recover,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [PW-1:0] pix_data,
  output logic          vid_hsync,
  output logic          vid_vsync,
  output logic          vid_de,
  output logic [PW-1:0] vid_pixel,
  output logic          frame_start
);
  localparam int SW = FW + 1;

  logic          act_en, act_hpol, act_vpol, act_recover;
  logic [HW-1:0] act_hperiod, act_hpulse, act_hstart, act_hend, act_skew;
  logic [FW-1:0] act_fperiod, act_vlen, act_vstart, act_vend;
  logic [PW-1:0] act_border, act_ufcol;
  logic [HW-1:0] hcnt;
  logic [FW-1:0] fcnt;
  logic          wrap, load;
  logic          h_act, v_act, h_win, v_win;
  logic [SW-1:0] vs_begin, vs_stop;

  assign load = !act_en || wrap;

  flvtg_shadow #(.HW(HW), .FW(FW), .PW(PW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_en(cfg_enable), .in_hperiod(cfg_hperiod), .in_hpulse(cfg_hpulse),
    .in_hstart(cfg_hstart), .in_hend(cfg_hend), .in_fperiod(cfg_fperiod),
    .in_vlen(cfg_vlen), .in_vstart(cfg_vstart), .in_vend(cfg_vend),
    .in_skew(cfg_skew), .in_hpol(cfg_hsync_low), .in_vpol(cfg_vsync_low),
    .in_border(cfg_border), .in_ufcol(cfg_uf_color), .in_recover(cfg_uf_recover),
    .q_en(act_en), .q_hperiod(act_hperiod), .q_hpulse(act_hpulse),
    .q_hstart(act_hstart), .q_hend(act_hend), .q_fperiod(act_fperiod),
    .q_vlen(act_vlen), .q_vstart(act_vstart), .q_vend(act_vend),
    .q_skew(act_skew), .q_hpol(act_hpol), .q_vpol(act_vpol),
    .q_border(act_border), .q_ufcol(act_ufcol), .q_recover(act_recover)
  );

  flvtg_counters #(.HW(HW), .FW(FW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(act_en),
    .hperiod(act_hperiod), .fperiod(act_fperiod),
    .hcnt(hcnt), .fcnt(fcnt), .wrap(wrap)
  );

  // Vertical sync as a span of the frame counter, shifted by the skew.
  assign vs_begin = SW'(act_skew);
  assign vs_stop  = vs_begin + {1'b0, act_vlen};
  assign h_act    = hcnt < act_hpulse;
  assign v_act    = ({1'b0, fcnt} >= vs_begin) && ({1'b0, fcnt} < vs_stop);
  assign h_win    = (hcnt >= act_hstart) && (hcnt <= act_hend);
  assign v_win    = (fcnt >= act_vstart) && (fcnt <= act_vend);

  assign vid_hsync   = (act_en && h_act) ^ act_hpol;
  assign vid_vsync   = (act_en && v_act) ^ act_vpol;
  assign vid_de      = act_en && h_win && v_win;
  assign pix_ready   = vid_de;
  assign frame_start = act_en && (fcnt == '0);

  flvtg_pixsel #(.PW(PW)) u_pix (
    .clk(clk), .rst_n(rst_n), .run(act_en), .de(vid_de), .wrap(wrap),
    .recover(act_recover), .pix_valid(pix_valid), .pix_data(pix_data),
    .border(act_border), .ufcol(act_ufcol), .pixel(vid_pixel)
  );
endmodule

// File: rtl/flvtg_checker.sv
module flvtg_checker #(
  parameter int HW = 12,
  parameter int FW = 24,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act_en,
  input logic          wrap,
  input logic [HW-1:0] act_hperiod,
  input logic [FW-1:0] act_fperiod,
  input logic          act_hpol,
  input logic          act_vpol,
  input logic [PW-1:0] act_ufcol,
  input logic          frame_start,
  input logic          vid_de,
  input logic          vid_hsync,
  input logic          vid_vsync,
  input logic          pix_valid,
  input logic [PW-1:0] vid_pixel
);
  assert_fs_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && act_fperiod > 1 && !wrap) |=> !frame_start);

  assert_de_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> !vid_de);

  assert_idle_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> (vid_hsync == act_hpol) && (vid_vsync == act_vpol));

  assert_hold_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && !wrap) |=> act_en && $stable(act_hperiod) && $stable(act_fperiod));

  assert_uf_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_de && !pix_valid) |-> vid_pixel == act_ufcol);
endmodule

bind frame_linear_vtg flvtg_checker #(.HW(HW), .FW(FW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_en(act_en), .wrap(wrap),
  .act_hperiod(act_hperiod), .act_fperiod(act_fperiod),
  .act_hpol(act_hpol), .act_vpol(act_vpol), .act_ufcol(act_ufcol),
  .frame_start(frame_start), .vid_de(vid_de), .vid_hsync(vid_hsync),
  .vid_vsync(vid_vsync), .pix_valid(pix_valid), .vid_pixel(vid_pixel)
);

// File: tb/frame_linear_vtg_test.sv
`timescale 1ns/1ps
module frame_linear_vtg_test;
  localparam int HW = 12, FW = 24, PW = 24;
  localparam logic [PW-1:0] BORDER = 24'h0000C3;
  localparam logic [PW-1:0] UFC    = 24'hFF00FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic          cfg_enable = 0, cfg_hsync_low = 0, cfg_vsync_low = 0, cfg_uf_recover = 1;
  logic [HW-1:0] cfg_hperiod = 8, cfg_hpulse = 2, cfg_hstart = 2, cfg_hend = 5, cfg_skew = 0;
  logic [FW-1:0] cfg_fperiod = 48, cfg_vlen = 8, cfg_vstart = 16, cfg_vend = 39;
  logic [PW-1:0] cfg_border = BORDER, cfg_uf_color = UFC, pix_data = 0;
  logic          pix_valid = 1;
  logic          pix_ready, vid_hsync, vid_vsync, vid_de, frame_start;
  logic [PW-1:0] vid_pixel;

  int checks = 0, failures = 0;
  bit done = 0;
  bit uf_exp = 0;

  always #10 clk = ~clk;

  frame_linear_vtg #(.HW(HW), .FW(FW), .PW(PW)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Scans one whole frame from frame_start, comparing every cycle with the model.
  task automatic scan_frame(input int hp, hw, fp, vl, hs, he, vs, ve, sk,
                            input bit hpl, vpl, input int uf_at,
                            input bit clr_at_start, input int op);
    int guard = 0;
    forever begin
      @(negedge clk); pix_valid = 1; pix_data = 24'h5A0000; #1;
      if (frame_start) break;
      guard++;
      if (guard > 4 * fp) begin
        chk(0, "R5", "frame_start missing", 0, 1);
        return;
      end
    end
    if (clr_at_start) uf_exp = 0;
    for (int k = 0; k < fp; k++) begin
      int h;
      bit e_hs, e_vs, e_de;
      logic [PW-1:0] e_px;
      if (k > 0) begin
        @(negedge clk);
        pix_valid = (k != uf_at);
        pix_data  = 24'h5A0000 | PW'(k);
        #1;
      end
      h    = k % hp;
      e_hs = (h < hw) ^ hpl;
      e_vs = (k >= sk && k < sk + vl) ^ vpl;
      e_de = (h >= hs) && (h <= he) && (k >= vs) && (k <= ve);
      if (!e_de) e_px = BORDER;
      else if (uf_exp || !pix_valid) e_px = UFC;
      else e_px = pix_data;
      if (e_de && !pix_valid) uf_exp = 1;
      chk(vid_hsync == e_hs, "R1", "hsync", vid_hsync, e_hs);
      chk(vid_vsync == e_vs, "R2", "vsync", vid_vsync, e_vs);
      chk(vid_de == e_de, "R3", "de", vid_de, e_de);
      chk(vid_pixel == e_px, (k == uf_at || uf_exp) ? "R8" : "R4", "pixel", vid_pixel, e_px);
      chk(frame_start == (k == 0), "R5", "frame_start", frame_start, k == 0);
      chk(pix_ready == e_de, "R11", "ready", pix_ready, e_de);
      if (k == fp / 2) begin
        if (op == 1) cfg_hpulse = 3;     // must wait for frame boundary (R6)
        if (op == 2) cfg_enable = 0;     // must finish this frame (R10)
      end
    end
  endtask

  task automatic check_idle(input int n, input bit hpl, vpl, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chk(vid_hsync == hpl, req, "idle hsync", vid_hsync, hpl);
      chk(vid_vsync == vpl, req, "idle vsync", vid_vsync, vpl);
      chk(vid_de == 0, req, "idle de", vid_de, 0);
      chk(vid_pixel == 0, "R4", "idle pixel", vid_pixel, 0);
      chk(frame_start == 0, req, "idle frame_start", frame_start, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_idle(5, 0, 0, "R10");
  endtask

  task automatic t_basic();
    cfg_enable = 1;
    @(negedge clk); #1;   // next cycle enabled: first frame position
    chk(frame_start == 1, "R6", "start after enable", frame_start, 1);
    scan_frame(8, 2, 48, 8, 2, 5, 16, 39, 0, 0, 0, -1, 1, 0);
    scan_frame(8, 2, 48, 8, 2, 5, 16, 39, 0, 0, 0, -1, 1, 0);
  endtask

  task automatic t_midchange();
    scan_frame(8, 2, 48, 8, 2, 5, 16, 39, 0, 0, 0, -1, 1, 1);
    scan_frame(8, 3, 48, 8, 2, 5, 16, 39, 0, 0, 0, -1, 1, 0);  // R6 new width now
  endtask

  task automatic t_skew_window();
    cfg_skew = 3; cfg_vstart = 19; cfg_vend = 42; cfg_hstart = 0; cfg_hend = 7;
    scan_frame(8, 3, 48, 8, 0, 7, 19, 42, 3, 0, 0, -1, 1, 0);
  endtask

  task automatic t_polarity();
    cfg_hsync_low = 1; cfg_vsync_low = 1; cfg_hstart = 2; cfg_hend = 5;
    scan_frame(8, 3, 48, 8, 2, 5, 19, 42, 3, 1, 1, -1, 1, 0);   // R7
  endtask

  task automatic t_underflow_recover();
    scan_frame(8, 3, 48, 8, 2, 5, 19, 42, 3, 1, 1, 20, 1, 0);   // R8
    scan_frame(8, 3, 48, 8, 2, 5, 19, 42, 3, 1, 1, -1, 1, 0);   // R9 recovered
  endtask

  task automatic t_underflow_sticky();
    cfg_uf_recover = 0;
    scan_frame(8, 3, 48, 8, 2, 5, 19, 42, 3, 1, 1, 20, 1, 0);
    scan_frame(8, 3, 48, 8, 2, 5, 19, 42, 3, 1, 1, -1, 0, 0);   // R9 persists
  endtask

  task automatic t_disable();
    scan_frame(8, 3, 48, 8, 2, 5, 19, 42, 3, 1, 1, -1, 0, 2);   // R10 frame completes
    check_idle(60, 1, 1, "R10");                               // R7 inactive high
    cfg_uf_recover = 1;
    cfg_enable = 1;                                           // R6 immediate when stopped
    scan_frame(8, 3, 48, 8, 2, 5, 19, 42, 3, 1, 1, -1, 1, 0);   // underflow cleared by stop
  endtask

  initial begin
    t_reset();
    t_basic();
    t_midchange();
    t_skew_window();
    t_polarity();
    t_underflow_recover();
    t_underflow_sticky();
    t_disable();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule